// File: doc/BRIEF.md
# Interrupt Event Combiner Bank

The block gathers a wide set of single-cycle event pulses, arranged as several groups of equal width, and latches each pulse into a sticky flag bit. Software manages the flags through a small register port. It can force flags high, drop them one bit at a time, and block them with a mask per group. Each group raises one combined interrupt line while any of its unblocked flags is set. A second, independent mask per group gives an exception view over the same flags, and the exception views of all groups are ORed into one exception output.

A handler for group g reads that group's masked-flag view, takes the lowest set bit, writes that bit to the group's clear register, and repeats until the view reads zero. Software can also raise any event by writing the event's number to a dedicated register. An event pulse that arrives in the same cycle as a clear of its flag is kept, so no event is lost during servicing.

Top module: `evt_combiner_bank`

## Requirements
- R1: While and after reset, every flag reads 0, both mask views of every group read all ones, and irq_o and exc_o are 0.
- R2: A pulse on evt_i[n] at a rising clock edge sets flag bit n%32 of group n/32 from that edge on, and the flag stays set after the pulse ends.
- R3: A write to the clear register of group g (kind 2) clears each flag bit whose wdata bit is 1 and leaves every bit whose wdata bit is 0 unchanged.
- R4: A write to the set register of group g (kind 1) sets each flag bit whose wdata bit is 1 and leaves the others unchanged.
- R5: The interrupt mask of group g (kind 3) is read/write, a 1 blocks the bit, and the interrupt masked-flag view (kind 4) reads flag AND NOT interrupt mask.
- R6: irq_o[g] is 1 exactly while the interrupt masked-flag view of group g is nonzero, updated in the same cycle as the flag or mask change.
- R7: The exception mask (kind 5, read/write, 1 blocks) and exception masked-flag view (kind 6, flag AND NOT exception mask) act on the same flags, and exc_o is 1 exactly while any group's exception view is nonzero.
- R8: When an event pulse on a bit coincides with a clear write covering that bit, the flag is set after the edge.
- R9: A write to kind 7 sets the single flag numbered wdata[6:0] (group wdata[6:5], bit wdata[4:0]); the other wdata bits and the address group bits are ignored.
- R10: reg_addr is {kind[2:0], group[1:0]}; reads of kinds 1, 2 and 7 return 0; writes to the read-only kinds 0, 4 and 6 change nothing; reg_rdata follows reg_addr in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | 128 | Event pulses, bit n belongs to group n/32 |
| reg_we | input | 1 | Register write strobe, applied at the rising edge |
| reg_addr | input | 5 | Register address {kind, group} |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |
| irq_o | output | 4 | Combined interrupt per group |
| exc_o | output | 1 | Combined exception output |

## Verification
A flag that is wrongly set or lost shows on the raw flag view and, when it is unblocked, on the matching irq_o or exc_o line right after the offending edge. A mask that has been corrupted stays hidden until a flag in its group appears, and then it shows as a wrong level on irq_o or exc_o. A wrong decode of the kind or group fields sends a write to the wrong place, and it shows on the next read of either place. Because of this, the bench compares irq_o and exc_o after every random step and reads back the whole register set every few steps.

// File: rtl/evt_comb_pkg.sv
package evt_comb_pkg;

   localparam int KIND_W = 3;

   typedef enum logic [KIND_W-1:0] {
      K_FLAG   = 3'd0,
      K_SET    = 3'd1,
      K_CLR    = 3'd2,
      K_IMASK  = 3'd3,
      K_IMFLAG = 3'd4,
      K_XMASK  = 3'd5,
      K_XMFLAG = 3'd6,
      K_SWEVT  = 3'd7
   } reg_kind_e;

endpackage

// File: rtl/comb_group.sv
module comb_group #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] evt,
   input  logic [W-1:0] sw_hit,
   input  logic         set_we,
   input  logic         clr_we,
   input  logic         imask_we,
   input  logic         xmask_we,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] flag,
   output logic [W-1:0] imask,
   output logic [W-1:0] xmask,
   output logic [W-1:0] imflag,
   output logic [W-1:0] xmflag
);

   logic [W-1:0] set_bits;
   logic [W-1:0] clr_bits;
   logic [W-1:0] flag_d;

   assign set_bits = set_we ? wdata : '0;
   assign clr_bits = clr_we ? wdata : '0;

   // clear first, then OR in new arrivals: a coincident event survives
   assign flag_d = (flag & ~clr_bits) | set_bits | evt | sw_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag  <= '0;
         imask <= '1;
         xmask <= '1;
      end else begin
         flag <= flag_d;
         if (imask_we) imask <= wdata;
         if (xmask_we) xmask <= wdata;
      end
   end

   assign imflag = flag & ~imask;
   assign xmflag = flag & ~xmask;

endmodule

// File: rtl/comb_swevt_dec.sv
module comb_swevt_dec #(
   parameter int NG = 4,
   parameter int W  = 32,
   localparam int BIT_W = $clog2(W),
   localparam int GRP_W = $clog2(NG),
   localparam int IDX_W = BIT_W + GRP_W
) (
   input  logic                  we,
   input  logic [IDX_W-1:0]      num,
   output logic [NG-1:0][W-1:0]  hit
);

   for (genvar g = 0; g < NG; g++) begin : g_grp
      logic sel;
      assign sel    = we && (num[IDX_W-1:BIT_W] == GRP_W'(g));
      assign hit[g] = sel ? (W'(1) << num[BIT_W-1:0]) : '0;
   end

endmodule

// File: rtl/comb_regsel.sv
module comb_regsel
   import evt_comb_pkg::*;
#(
   parameter int NG = 4,
   parameter int W  = 32,
   localparam int GRP_W = $clog2(NG)
) (
   input  reg_kind_e             kind,
   input  logic [GRP_W-1:0]      grp,
   input  logic [NG-1:0][W-1:0]  flag,
   input  logic [NG-1:0][W-1:0]  imask,
   input  logic [NG-1:0][W-1:0]  xmask,
   input  logic [NG-1:0][W-1:0]  imflag,
   input  logic [NG-1:0][W-1:0]  xmflag,
   output logic [W-1:0]          rdata
);

   always_comb begin
      unique case (kind)
         K_FLAG:   rdata = flag[grp];
         K_IMASK:  rdata = imask[grp];
         K_IMFLAG: rdata = imflag[grp];
         K_XMASK:  rdata = xmask[grp];
         K_XMFLAG: rdata = xmflag[grp];
         default:  rdata = '0;
      endcase
   end

endmodule

// File: rtl/evt_combiner_bank.sv
module evt_combiner_bank
   import evt_comb_pkg::*;
#(
   parameter int NUM_GROUPS = 4,
   parameter int GROUP_W    = 32,
   localparam int NUM_EVT = NUM_GROUPS * GROUP_W,
   localparam int GRP_W   = $clog2(NUM_GROUPS),
   localparam int IDX_W   = $clog2(NUM_EVT),
   localparam int ADDR_W  = KIND_W + GRP_W
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_EVT-1:0]    evt_i,
   input  logic                  reg_we,
   input  logic [ADDR_W-1:0]     reg_addr,
   input  logic [GROUP_W-1:0]    reg_wdata,
   output logic [GROUP_W-1:0]    reg_rdata,
   output logic [NUM_GROUPS-1:0] irq_o,
   output logic                  exc_o
);

   if (NUM_GROUPS < 2 || (NUM_GROUPS & (NUM_GROUPS - 1)) != 0) begin : g_bad_ng
      $error("NUM_GROUPS must be a power of two, at least 2");
   end
   if (GROUP_W < 2 || (GROUP_W & (GROUP_W - 1)) != 0) begin : g_bad_w
      $error("GROUP_W must be a power of two, at least 2");
   end
   if (IDX_W > GROUP_W) begin : g_bad_idx
      $error("event number must fit in one data word");
   end

   reg_kind_e        kind;
   logic [GRP_W-1:0] grp;

   assign kind = reg_kind_e'(reg_addr[ADDR_W-1 -: KIND_W]);
   assign grp  = reg_addr[GRP_W-1:0];

   logic [NUM_GROUPS-1:0][GROUP_W-1:0] evt_grp;
   logic [NUM_GROUPS-1:0][GROUP_W-1:0] sw_hit;
   logic [NUM_GROUPS-1:0][GROUP_W-1:0] flag_all;
   logic [NUM_GROUPS-1:0][GROUP_W-1:0] imask_all;
   logic [NUM_GROUPS-1:0][GROUP_W-1:0] xmask_all;
   logic [NUM_GROUPS-1:0][GROUP_W-1:0] imflag_all;
   logic [NUM_GROUPS-1:0][GROUP_W-1:0] xmflag_all;
   logic [NUM_GROUPS-1:0]              exc_grp;

   assign evt_grp = evt_i;

   comb_swevt_dec #(
      .NG (NUM_GROUPS),
      .W  (GROUP_W)
   ) u_swdec (
      .we  (reg_we && kind == K_SWEVT),
      .num (reg_wdata[IDX_W-1:0]),
      .hit (sw_hit)
   );

   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_bank
      logic here;
      assign here = reg_we && (grp == GRP_W'(g));

      comb_group #(
         .W (GROUP_W)
      ) u_grp (
         .clk      (clk),
         .rst_n    (rst_n),
         .evt      (evt_grp[g]),
         .sw_hit   (sw_hit[g]),
         .set_we   (here && kind == K_SET),
         .clr_we   (here && kind == K_CLR),
         .imask_we (here && kind == K_IMASK),
         .xmask_we (here && kind == K_XMASK),
         .wdata    (reg_wdata),
         .flag     (flag_all[g]),
         .imask    (imask_all[g]),
         .xmask    (xmask_all[g]),
         .imflag   (imflag_all[g]),
         .xmflag   (xmflag_all[g])
      );

      assign irq_o[g]   = |imflag_all[g];
      assign exc_grp[g] = |xmflag_all[g];
   end

   assign exc_o = |exc_grp;

   comb_regsel #(
      .NG (NUM_GROUPS),
      .W  (GROUP_W)
   ) u_rsel (
      .kind   (kind),
      .grp    (grp),
      .flag   (flag_all),
      .imask  (imask_all),
      .xmask  (xmask_all),
      .imflag (imflag_all),
      .xmflag (xmflag_all),
      .rdata  (reg_rdata)
   );

endmodule

// File: rtl/evt_combiner_bank_chk.sv
module evt_combiner_bank_chk
   import evt_comb_pkg::*;
#(
   parameter int NUM_GROUPS = 4,
   parameter int GROUP_W    = 32,
   localparam int NUM_EVT = NUM_GROUPS * GROUP_W,
   localparam int GRP_W   = $clog2(NUM_GROUPS),
   localparam int ADDR_W  = KIND_W + GRP_W
) (
   input logic                               clk,
   input logic                               rst_n,
   input logic [NUM_EVT-1:0]                 evt_i,
   input logic                               reg_we,
   input logic [ADDR_W-1:0]                  reg_addr,
   input logic [GROUP_W-1:0]                 reg_wdata,
   input logic [NUM_GROUPS-1:0]              irq_o,
   input logic                               exc_o,
   input logic [NUM_GROUPS-1:0][GROUP_W-1:0] flag_all
);

   logic [NUM_GROUPS-1:0][GROUP_W-1:0] evt_grp;
   logic [NUM_GROUPS-1:0]              grp_nz;
   logic                               valid_q;
   logic                               hold_q;
   logic                               clr_q;
   logic [GRP_W-1:0]                   grp_q;
   logic [GROUP_W-1:0]                 cmask_q;
   logic [NUM_EVT-1:0]                 evt_q;
   logic [NUM_EVT-1:0]                 flag_q;
   logic                               is_clr;
   logic [GRP_W-1:0]                   cur_grp;

   assign evt_grp = evt_i;
   assign is_clr  = reg_we && reg_addr[ADDR_W-1 -: KIND_W] == K_CLR;
   assign cur_grp = reg_addr[GRP_W-1:0];

   always_comb begin
      for (int g = 0; g < NUM_GROUPS; g++) grp_nz[g] = |flag_all[g];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         hold_q  <= 1'b0;
         clr_q   <= 1'b0;
         grp_q   <= '0;
         cmask_q <= '0;
         evt_q   <= '0;
         flag_q  <= '0;
      end else begin
         valid_q <= 1'b1;
         hold_q  <= !reg_we && evt_i == '0;
         clr_q   <= is_clr;
         grp_q   <= cur_grp;
         cmask_q <= reg_wdata & ~evt_grp[cur_grp];
         evt_q   <= evt_i;
         flag_q  <= flag_all;
      end
   end

   AST_EVT_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
      valid_q |-> ((flag_all & evt_q) == evt_q));                       // R2

   AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_q && clr_q) |-> ((flag_all[grp_q] & cmask_q) == '0));      // R3

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_q && hold_q) |-> (flag_all == flag_q));                    // R4

   AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o & ~grp_nz) == '0);                                          // R6

   AST_EXC_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      exc_o |-> (|grp_nz));                                              // R7

endmodule

bind evt_combiner_bank evt_combiner_bank_chk #(
   .NUM_GROUPS (NUM_GROUPS),
   .GROUP_W    (GROUP_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .evt_i     (evt_i),
   .reg_we    (reg_we),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata),
   .irq_o     (irq_o),
   .exc_o     (exc_o),
   .flag_all  (flag_all)
);

// File: tb/evt_combiner_bank_tb.sv
module evt_combiner_bank_tb;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [127:0] evt_i = '0;
   logic         reg_we = 1'b0;
   logic [4:0]   reg_addr = '0;
   logic [31:0]  reg_wdata = '0;
   logic [31:0]  reg_rdata;
   logic [3:0]   irq_o;
   logic         exc_o;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   logic [31:0] m_flag [4];
   logic [31:0] m_im   [4];
   logic [31:0] m_xm   [4];

   always #5 clk = ~clk;

   evt_combiner_bank u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .evt_i     (evt_i),
      .reg_we    (reg_we),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .irq_o     (irq_o),
      .exc_o     (exc_o)
   );

   task automatic chk(input bit ok, input string req, input logic [127:0] act,
                      input logic [127:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_read(input logic [4:0] a);
      int g = int'(a[1:0]);
      case (a[4:2])
         3'd0:    return m_flag[g];
         3'd3:    return m_im[g];
         3'd4:    return m_flag[g] & ~m_im[g];
         3'd5:    return m_xm[g];
         3'd6:    return m_flag[g] & ~m_xm[g];
         default: return 32'h0;
      endcase
   endfunction

   function automatic string req_of(input logic [2:0] k);
      case (k)
         3'd0:          return "R2 flag view";
         3'd3, 3'd4:    return "R5 interrupt view";
         3'd5, 3'd6:    return "R7 exception view";
         default:       return "R10 write-only reads zero";
      endcase
   endfunction

   function automatic logic [3:0] exp_irq();
      logic [3:0] r;
      for (int g = 0; g < 4; g++) r[g] = |(m_flag[g] & ~m_im[g]);
      return r;
   endfunction

   function automatic logic exp_exc();
      logic r = 1'b0;
      for (int g = 0; g < 4; g++) r |= |(m_flag[g] & ~m_xm[g]);
      return r;
   endfunction

   task automatic model_reset();
      for (int g = 0; g < 4; g++) begin
         m_flag[g] = '0; m_im[g] = '1; m_xm[g] = '1;
      end
   endtask

   task automatic model_step(input logic we, input logic [4:0] a,
                             input logic [31:0] d, input logic [127:0] ev);
      int g = int'(a[1:0]);
      if (we) begin
         case (a[4:2])
            3'd1: m_flag[g] |= d;
            3'd2: m_flag[g] &= ~d;
            3'd3: m_im[g] = d;
            3'd5: m_xm[g] = d;
            3'd7: m_flag[d[6:5]][d[4:0]] = 1'b1;
            default: ;
         endcase
      end
      for (int k = 0; k < 4; k++) m_flag[k] |= ev[k*32 +: 32];
   endtask

   task automatic cyc(input logic we, input logic [4:0] a,
                      input logic [31:0] d, input logic [127:0] ev);
      @(negedge clk);
      reg_we = we; reg_addr = a; reg_wdata = d; evt_i = ev;
      @(posedge clk);
      model_step(we, a, d, ev);
      #1;
      reg_we = 1'b0; evt_i = '0;
   endtask

   task automatic rd(input logic [4:0] a, input string req);
      @(negedge clk);
      reg_addr = a;
      #1;
      chk(reg_rdata === exp_read(a), req, reg_rdata, exp_read(a));
   endtask

   task automatic chk_outs(input string req);
      @(negedge clk);
      chk(irq_o === exp_irq(), {req, " irq_o"}, irq_o, exp_irq());
      chk(exc_o === exp_exc(), {req, " exc_o"}, exc_o, exp_exc());
   endtask

   task automatic chk_all();
      for (int k = 0; k < 8; k++)
         for (int g = 0; g < 4; g++)
            rd({k[2:0], g[1:0]}, req_of(k[2:0]));
      chk_outs("R6 R7");
   endtask

   initial begin
      void'($urandom(32'h5EED_0C0B));
      model_reset();
      repeat (3) @(posedge clk);
      // R1: values while reset is held
      @(negedge clk);
      chk(irq_o === 4'h0 && exc_o === 1'b0, "R1 outputs in reset",
          {irq_o, exc_o}, 5'h0);
      rst_n = 1'b1;
      // R1: values after reset release
      chk_all();

      // R2: a single event pulse latches and stays, masked
      cyc(1'b0, '0, '0, 128'h1 << 37);
      chk_outs("R2 masked event keeps outputs low");
      rd({3'd0, 2'd1}, "R2 latched flag");
      repeat (2) @(negedge clk);
      rd({3'd0, 2'd1}, "R2 flag sticky");

      // R5 R6: unmask group 1, irq rises
      cyc(1'b1, {3'd3, 2'd1}, 32'hFFFF_FFDF, '0);
      chk_outs("R6 irq follows unmask");
      rd({3'd4, 2'd1}, "R5 masked flag view");

      // R7: exception view of group 1 independent of interrupt mask
      cyc(1'b1, {3'd5, 2'd1}, 32'hFFFF_FFDF, '0);
      chk_outs("R7 exception rises");
      rd({3'd6, 2'd1}, "R7 exception view");

      // R8: event and clear of the same bit in one cycle
      cyc(1'b1, {3'd2, 2'd1}, 32'h0000_0020, 128'h1 << 37);
      rd({3'd0, 2'd1}, "R8 event survives clear");
      chk_outs("R8 outputs stay high");

      // R3: clear with zero changes nothing, then real clear
      cyc(1'b1, {3'd2, 2'd1}, 32'h0, '0);
      rd({3'd0, 2'd1}, "R3 zero clear no effect");
      cyc(1'b1, {3'd2, 2'd1}, 32'h0000_0020, '0);
      rd({3'd0, 2'd1}, "R3 clear drops flag");
      chk_outs("R3 outputs fall after clear");

      // R9: software event, upper data bits and address group ignored
      cyc(1'b1, {3'd7, 2'd2}, 32'hABCD_FF80 | 32'd97, '0);
      rd({3'd0, 2'd3}, "R9 software event sets flag 97");
      rd({3'd0, 2'd2}, "R9 address group ignored");

      // R10: writes to read-only views change nothing
      cyc(1'b1, {3'd0, 2'd3}, 32'hFFFF_FFFF, '0);
      cyc(1'b1, {3'd4, 2'd3}, 32'hFFFF_FFFF, '0);
      cyc(1'b1, {3'd6, 2'd3}, 32'hFFFF_FFFF, '0);
      rd({3'd0, 2'd3}, "R10 read-only write ignored");
      rd({3'd3, 2'd3}, "R10 mask untouched");

      // R4 R3: service loop, lowest bit first
      cyc(1'b1, {3'd1, 2'd0}, 32'h8421_0010, '0);
      cyc(1'b1, {3'd3, 2'd0}, 32'h0, '0);
      chk_outs("R4 set raises irq");
      begin
         int serviced = 0;
         for (int it = 0; it < 40; it++) begin
            logic [31:0] v;
            @(negedge clk);
            reg_addr = {3'd4, 2'd0};
            #1;
            v = reg_rdata;
            if (v == 0) break;
            for (int b = 0; b < 32; b++) begin
               if (v[b]) begin
                  cyc(1'b1, {3'd2, 2'd0}, 32'h1 << b, '0);
                  break;
               end
            end
            serviced++;
         end
         chk(serviced == 5, "R3 service loop count", serviced, 5);
      end
      chk_outs("R6 irq low after service");
      chk_all();

      // random phase
      for (int it = 0; it < 600; it++) begin
         logic [127:0] ev = '0;
         logic [31:0]  d  = $urandom;
         logic [2:0]   k  = 3'($urandom % 8);
         logic [1:0]   g  = 2'($urandom % 4);
         logic         we = ($urandom % 4) != 0;
         if ($urandom % 3 == 0)
            for (int q = 0; q < 4; q++)
               ev[q*32 +: 32] = $urandom & $urandom & $urandom;
         if (k == 3'd3 || k == 3'd5) d = d & $urandom;
         cyc(we, {k, g}, d, ev);
         chk_outs("R6 R7 random");
         if (it % 50 == 49) chk_all();
      end

      done = 1'b1;
   end

   initial begin
      fork
         begin
            repeat (200000) @(posedge clk);
            chk(1'b0, "watchdog expired", 0, 1);
         end
         wait (done);
      join_any
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule